// File: doc/BRIEF.md
# Sequential Restoring Divider

This block divides an unsigned dividend by an unsigned divisor of the same width (8 bits by default) one quotient bit at a time. It keeps a remainder register one bit wider than the operands, a dividend register that fills up with quotient bits, and a divisor register. A request is accepted with a one-cycle `start` pulse while the block is idle. The block then runs one iteration per quotient bit. Each iteration shifts the remainder and dividend pair left, makes a trial subtraction of the divisor, and reads the sign of the difference. A negative difference costs one extra cycle to add the divisor back.

When the last iteration ends, `done` pulses for one cycle. From that cycle onward, `quotient` and `remainder` hold the result until the next request. A zero divisor runs the same sequence without any special path. It returns an all-ones quotient and a remainder equal to the dividend, and it raises `div_by_zero`.

The controller is a state machine with five states. IDLE waits for a request, and `start` in IDLE loads the operands and moves to SHIFT. SHIFT moves the pair left and always goes to TRIAL. TRIAL writes the difference and the quotient bit. A negative difference leads to FIXUP. A non-negative difference leads to SHIFT, or to FIN after the last iteration. FIXUP adds the divisor back, then goes to SHIFT, or to FIN after the last iteration. FIN raises `done` and returns unconditionally to IDLE.

Top module: `restoring_divider`

## Requirements
- R1: After reset, `busy`, `done` and `div_by_zero` are 0, and `quotient` and `remainder` read 0.
- R2: A `start` pulse while idle captures `dividend` and `divisor`, clears the remainder, and drives `busy` high from the next cycle on.
- R3: Each iteration takes two cycles. The first shifts the remainder:dividend pair left by one bit. The second subtracts the divisor in 9-bit arithmetic, where bit 8 is the sign, and writes 1 into the quotient LSB when the difference is non-negative.
- R4: A negative trial difference sets the quotient LSB to 0 and takes one extra cycle that adds the divisor back. `busy` therefore stays high for exactly 2·8 + (number of zero bits in the quotient) cycles.
- R5: After 8 iterations, `done` is high for exactly one cycle, with `busy` low. `quotient` equals dividend/divisor, `remainder` equals dividend mod divisor, quotient·divisor + remainder equals dividend, and remainder < divisor. For example, 8/3 gives 2 remainder 2.
- R6: `quotient`, `remainder` and `div_by_zero` stay unchanged after `done` until the next accepted `start`.
- R7: `start` while `busy` is high is ignored: the running division finishes with its original operands and timing.
- R8: A divisor of 0 takes 16 busy cycles and then gives an all-ones quotient, a remainder equal to the dividend, and `div_by_zero` = 1.
- R9: `div_by_zero` is cleared by the next accepted `start` with a non-zero divisor.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request pulse, accepted only when idle |
| dividend | input | 8 | Unsigned dividend |
| divisor | input | 8 | Unsigned divisor |
| busy | output | 1 | Division in progress |
| done | output | 1 | One-cycle result strobe |
| quotient | output | 8 | Quotient |
| remainder | output | 8 | Remainder |
| div_by_zero | output | 1 | Last request had a zero divisor |

## Verification
A wrong restore decision or a miscounted iteration changes the length of the `busy` window, because every zero quotient bit adds one cycle. The bench compares `busy` and `done` with a model on every clock, so a sequencing error shows within a cycle of the divergence rather than only at the end. A wrong shift or sign test corrupts the quotient and remainder, and this shows in the `done` cycle as a broken quotient·divisor + remainder identity. A leaked `start` shows as a changed result or a changed window length.

// File: rtl/div_pkg.sv
package div_pkg;
    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_SHIFT = 3'd1,
        ST_TRIAL = 3'd2,
        ST_FIXUP = 3'd3,
        ST_FIN   = 3'd4
    } div_state_t;
endpackage

// File: rtl/div_addsub.sv
module div_addsub #(
    parameter int W = 8
) (
    input  logic [W:0] opa,
    input  logic [W:0] opb,
    input  logic       subtract,
    output logic [W:0] result
);
    logic [W:0] opb_eff;

    always_comb begin
        opb_eff = subtract ? ~opb : opb;
        result  = opa + opb_eff + {{W{1'b0}}, subtract};
    end
endmodule

// File: rtl/div_ctrl.sv
module div_ctrl
    import div_pkg::*;
#(
    parameter int W = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic trial_neg,
    output logic load,
    output logic do_shift,
    output logic do_trial,
    output logic do_fixup,
    output logic busy,
    output logic done
);
    localparam int CW = $clog2(W + 1);
    localparam logic [CW-1:0] LAST = CW'(W - 1);

    div_state_t state_q, state_d;
    logic [CW-1:0] iter_q;
    logic          last_iter;

    assign last_iter = (iter_q == LAST);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (start) state_d = ST_SHIFT;
            ST_SHIFT: state_d = ST_TRIAL;
            ST_TRIAL: begin
                if (trial_neg)      state_d = ST_FIXUP;
                else if (last_iter) state_d = ST_FIN;
                else                state_d = ST_SHIFT;
            end
            ST_FIXUP: state_d = last_iter ? ST_FIN : ST_SHIFT;
            ST_FIN:   state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            iter_q  <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE)
                iter_q <= '0;
            else if ((state_q == ST_TRIAL && !trial_neg) || state_q == ST_FIXUP)
                iter_q <= iter_q + 1'b1;
        end
    end

    always_comb begin
        load     = 1'b0;
        do_shift = 1'b0;
        do_trial = 1'b0;
        do_fixup = 1'b0;
        busy     = 1'b0;
        done     = 1'b0;
        unique case (state_q)
            ST_IDLE:  load = start;
            ST_SHIFT: begin do_shift = 1'b1; busy = 1'b1; end
            ST_TRIAL: begin do_trial = 1'b1; busy = 1'b1; end
            ST_FIXUP: begin do_fixup = 1'b1; busy = 1'b1; end
            ST_FIN:   done = 1'b1;
            default:  ;
        endcase
    end

    // R5: the result strobe lasts a single cycle
    a_r5_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R5: the strobe and the busy window never overlap
    a_r5_busy_done_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && done));
    // R7: a request is taken only in the idle state
    a_r7_load_idle_only: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> !busy && !done);
    // R4: a negative trial is always followed by the add-back cycle
    a_r4_fixup_follows: assert property (@(posedge clk) disable iff (!rst_n)
        (do_trial && trial_neg) |=> do_fixup);
endmodule

// File: rtl/div_datapath.sv
module div_datapath #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic         do_shift,
    input  logic         do_trial,
    input  logic         do_fixup,
    input  logic [W-1:0] dvd_in,
    input  logic [W-1:0] dvs_in,
    output logic         trial_neg,
    output logic [W-1:0] quo_out,
    output logic [W-1:0] rem_out,
    output logic         zero_div
);
    logic [W:0]   rem_q;
    logic [W-1:0] quo_q;
    logic [W-1:0] dvs_q;
    logic         zdiv_q;
    logic [W:0]   sum;

    div_addsub #(.W(W)) u_addsub (
        .opa      (rem_q),
        .opb      ({1'b0, dvs_q}),
        .subtract (!do_fixup),
        .result   (sum)
    );

    assign trial_neg = sum[W];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rem_q  <= '0;
            quo_q  <= '0;
            dvs_q  <= '0;
            zdiv_q <= 1'b0;
        end else if (load) begin
            rem_q  <= '0;
            quo_q  <= dvd_in;
            dvs_q  <= dvs_in;
            zdiv_q <= (dvs_in == '0);
        end else if (do_shift) begin
            rem_q <= {rem_q[W-1:0], quo_q[W-1]};
            quo_q <= {quo_q[W-2:0], 1'b0};
        end else if (do_trial) begin
            rem_q    <= sum;
            quo_q[0] <= !sum[W];
        end else if (do_fixup) begin
            rem_q <= sum;
        end
    end

    assign quo_out  = quo_q;
    assign rem_out  = rem_q[W-1:0];
    assign zero_div = zdiv_q;

    // R4: after the add-back the partial remainder is non-negative again
    a_r4_restored_positive: assert property (@(posedge clk) disable iff (!rst_n)
        do_fixup |=> !rem_q[W]);
    // R5: an accepted trial leaves a remainder below the divisor
    a_r5_rem_below_divisor: assert property (@(posedge clk) disable iff (!rst_n)
        (do_trial && !trial_neg) |=> (rem_q < {1'b0, dvs_q}) || (dvs_q == '0));
    // R7: the divisor register only changes on a load
    a_r7_divisor_held: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(dvs_q));
endmodule

// File: rtl/restoring_divider.sv
module restoring_divider #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic [W-1:0] dividend,
    input  logic [W-1:0] divisor,
    output logic         busy,
    output logic         done,
    output logic [W-1:0] quotient,
    output logic [W-1:0] remainder,
    output logic         div_by_zero
);
    logic load, do_shift, do_trial, do_fixup, trial_neg;

    div_ctrl #(.W(W)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .trial_neg (trial_neg),
        .load      (load),
        .do_shift  (do_shift),
        .do_trial  (do_trial),
        .do_fixup  (do_fixup),
        .busy      (busy),
        .done      (done)
    );

    div_datapath #(.W(W)) u_dp (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .do_shift  (do_shift),
        .do_trial  (do_trial),
        .do_fixup  (do_fixup),
        .dvd_in    (dividend),
        .dvs_in    (divisor),
        .trial_neg (trial_neg),
        .quo_out   (quotient),
        .rem_out   (remainder),
        .zero_div  (div_by_zero)
    );

    // R8: a zero divisor yields an all-ones quotient
    a_r8_zero_div_ones: assert property (@(posedge clk) disable iff (!rst_n)
        (done && div_by_zero) |-> (quotient == {W{1'b1}}));
    // R6: results hold while idle with no request
    a_r6_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (done || (!busy && !load)) |=> (busy || $stable(quotient)));
endmodule

// File: tb/restoring_divider_tb.sv
module restoring_divider_tb;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic [W-1:0] dividend = '0;
    logic [W-1:0] divisor = '0;
    logic         busy, done, div_by_zero;
    logic [W-1:0] quotient, remainder;

    int checks = 0;
    int errors = 0;

    restoring_divider #(.W(W)) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start),
        .dividend(dividend), .divisor(divisor),
        .busy(busy), .done(done), .quotient(quotient),
        .remainder(remainder), .div_by_zero(div_by_zero)
    );

    always #5 clk = ~clk;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    // Runs one division and compares busy/done on every clock against the model.
    // intrude > 0 pulses start with other operands in that busy cycle (R7).
    task automatic run(input int dvd, input int dvs, input int intrude);
        int exp_q, exp_r, len, zeros;
        bit exp_z;
        exp_z = (dvs == 0);
        exp_q = exp_z ? (1 << W) - 1 : dvd / dvs;
        exp_r = exp_z ? dvd : dvd % dvs;
        zeros = W - $countones(exp_q[W-1:0]);
        len   = 2 * W + zeros;
        @(negedge clk);
        start = 1'b1; dividend = W'(dvd); divisor = W'(dvs);
        @(negedge clk);
        start = 1'b0;
        for (int i = 0; i < len; i++) begin
            chk(busy === 1'b1, "R2/R4 busy window", int'(busy), 1);
            chk(done === 1'b0, "R5 no early done", int'(done), 0);
            if (intrude > 0 && i == intrude) begin
                start = 1'b1; dividend = W'(dvd ^ 8'h5A); divisor = W'(dvs + 3);
            end else begin
                start = 1'b0;
            end
            @(negedge clk);
        end
        start = 1'b0;
        chk(done === 1'b1 && busy === 1'b0, "R5 done strobe", int'(done), 1);
        chk(int'(quotient) == exp_q, exp_z ? "R8 quotient" : "R5 quotient", int'(quotient), exp_q);
        chk(int'(remainder) == exp_r, exp_z ? "R8 remainder" : "R5 remainder", int'(remainder), exp_r);
        chk(div_by_zero === exp_z, exp_z ? "R8 flag" : "R9 flag clear", int'(div_by_zero), int'(exp_z));
        if (!exp_z) begin
            chk(int'(quotient) * dvs + int'(remainder) == dvd, "R5 identity",
                int'(quotient) * dvs + int'(remainder), dvd);
            chk(int'(remainder) < dvs, "R5 remainder bound", int'(remainder), dvs);
        end
        if (intrude > 0)
            chk(int'(quotient) == exp_q, "R7 start ignored", int'(quotient), exp_q);
        @(negedge clk);
        chk(done === 1'b0 && busy === 1'b0, "R5 single pulse", int'(done), 0);
        @(negedge clk);
        chk(int'(quotient) == exp_q && int'(remainder) == exp_r, "R6 result held",
            int'(remainder), exp_r);
    endtask

    initial begin
        #1_000_000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(busy === 1'b0 && done === 1'b0, "R1 control idle", int'(busy), 0);
        chk(quotient === '0 && remainder === '0, "R1 outputs zero", int'(quotient), 0);
        chk(div_by_zero === 1'b0, "R1 flag clear", int'(div_by_zero), 0);
        rst_n = 1'b1;
        @(negedge clk);
        // R3/R4/R5: directed patterns
        run(8, 3, 0);
        run(255, 1, 0);
        run(0, 5, 0);
        run(255, 255, 0);
        run(7, 9, 0);
        run(128, 2, 0);
        run(170, 13, 0);
        // R8 then R9
        run(200, 0, 0);
        run(0, 0, 0);
        run(100, 7, 0);
        // R7: start while busy
        run(221, 6, 4);
        run(99, 0, 9);
        // random operands
        for (int k = 0; k < 60; k++)
            run(int'($urandom_range(0, 255)), int'($urandom_range(0, 255)), 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule